// File: doc/BRIEF.md
# Time-Slotted Ping-Pong Address FIFO

This block holds the sub-window addresses passed between three detector stages. It has two pairs of logical FIFOs. Each pair links a producing stage to a consuming stage, and each logical bank holds 20-bit words. All four banks live in a single single-port RAM. That RAM runs on a memory clock at exactly four times the FIFO clock, with both clocks phase-aligned. During each FIFO cycle, the four memory edges give four fixed access slots:

1. the read for pair 0,
2. the read for pair 1,
3. the write for pair 0,
4. the write for pair 1.

Within a pair the two banks act as a ping-pong buffer. The producer appends to the "fill" bank while the consumer drains the "drain" bank. A frame-boundary pulse exchanges the roles of the two banks. After the exchange, the consumer sees exactly the words produced during the previous frame. The bank handed back to the producer starts empty.

Each pair has its own push, pop and frame-boundary inputs. A push to a full fill bank is dropped. A pop from an empty drain bank is dropped. Each dropped request raises a one-cycle error flag. Popped words come back, registered, in the FIFO cycle after the pop. Reset is synchronous and active high. It must be released shortly after a FIFO clock edge, before the next memory-clock edge.

Top module: `ppaf_top`

## Requirements
- R1: During and right after reset, every drain bank reads empty (`drain_empty_o`=1) and no fill bank reads full. `pop_valid_o`, `push_err_o` and `pop_err_o` are 0, and `pop_word_o` is 0. After reset, bank 0 of each pair is the fill bank.
- R2: Within one frame, the consumer receives the words of a pair in the order they were pushed, with no loss or duplication.
- R3: Words pushed into a pair never become visible to that pair's consumer before the next frame-boundary pulse. While no pulse arrives, an empty drain bank stays empty whatever is pushed.
- R4: A frame-boundary pulse on a pair swaps its two banks. The old fill bank, with all its words, becomes the drain bank. The old drain bank becomes the fill bank and is emptied, so any words left unread in it are discarded.
- R5: A pop accepted in cycle k sets `pop_valid_o` in cycle k+1, with the popped word on `pop_word_o`. `pop_word_o` changes only in a cycle where `pop_valid_o` is 1.
- R6: Each bank holds DEPTH words, and `fill_full_o` shows when the fill bank holds DEPTH words. A push while it is full is dropped, and `push_err_o` is 1 in the following cycle.
- R7: A pop while the drain bank is empty is dropped. In the following cycle `pop_err_o` is 1, `pop_valid_o` is 0 and `pop_word_o` keeps its value.
- R8: Both pairs can push and pop in every FIFO cycle at the same time, and each pair's data is independent of the other's.
- R9: A push in the same cycle as a frame-boundary pulse goes into the bank that becomes the drain bank, after the words pushed before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | FIFO-side clock |
| clk_mem_i | input | 1 | Memory clock, 4x clk_i, rising edges aligned with clk_i |
| rst_i | input | 1 | Synchronous active-high reset, clk_i domain |
| push_i | input | 2 | Push request per pair |
| push_word_i | input | 2x20 | Word to push per pair |
| pop_i | input | 2 | Pop request per pair |
| frame_i | input | 2 | Frame-boundary pulse per pair (swap banks) |
| pop_word_o | output | 2x20 | Popped word per pair, registered |
| pop_valid_o | output | 2 | Popped word valid per pair |
| fill_full_o | output | 2 | Fill bank of the pair is full |
| drain_empty_o | output | 2 | Drain bank of the pair is empty |
| push_err_o | output | 2 | Previous-cycle push was dropped |
| pop_err_o | output | 2 | Previous-cycle pop was dropped |

## Verification
A wrong slot phase, or an address that points into the wrong bank region, shows up at the first pop after a frame swap. The word returned belongs to another bank or to another pair, so the scoreboard catches it in the cycle after that pop. A broken occupancy count appears within one cycle as a wrong `fill_full_o` or `drain_empty_o`, or as a missing or spurious error flag. Fill and drain tests run right up to the DEPTH boundary. A swap that fails to clear the returned bank is exposed one frame later, when discarded leftovers reappear in the pop stream.

// File: rtl/ppaf_pkg.sv
package ppaf_pkg;
  localparam int NUM_PAIRS      = 2;
  localparam int BANKS_PER_PAIR = 2;
  localparam int NUM_BANKS      = NUM_PAIRS * BANKS_PER_PAIR;
  // one read slot and one write slot per pair in every FIFO cycle
  localparam int NUM_SLOTS      = 2 * NUM_PAIRS;
  localparam int SLOT_W         = $clog2(NUM_SLOTS);

  // first physical word of a bank
  function automatic int bank_base(input int pair, input logic sel, input int depth);
    return (pair * BANKS_PER_PAIR + int'(sel)) * depth;
  endfunction
endpackage

// File: rtl/ppaf_bank_ctrl.sv
module ppaf_bank_ctrl #(
  parameter int DEPTH = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 push_i,
  input  logic                 pop_i,
  input  logic                 clear_i,
  output logic [(DEPTH>1 ? $clog2(DEPTH) : 1)-1:0] wptr_o,
  output logic [(DEPTH>1 ? $clog2(DEPTH) : 1)-1:0] rptr_o,
  output logic                 full_o,
  output logic                 empty_o,
  output logic                 push_ok_o,
  output logic                 pop_ok_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full_o    = (cnt == CW'(DEPTH));
  assign empty_o   = (cnt == '0);
  assign push_ok_o = push_i && !full_o;
  assign pop_ok_o  = pop_i && !empty_o;
  assign wptr_o    = wp;
  assign rptr_o    = rp;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok_o) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok_o)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_ok_o) - CW'(pop_ok_o);
    end
  end
endmodule

// File: rtl/ppaf_pair_ctrl.sv
module ppaf_pair_ctrl
  import ppaf_pkg::*;
#(
  parameter int WORD_W   = 20,
  parameter int DEPTH    = 256,
  parameter int PAIR_IDX = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic                              push_i,
  input  logic [WORD_W-1:0]                 push_word_i,
  input  logic                              pop_i,
  input  logic                              frame_i,
  input  logic [WORD_W-1:0]                 hold_word_i,
  output logic                              mem_rd_o,
  output logic [$clog2(NUM_BANKS*DEPTH)-1:0] mem_rd_addr_o,
  output logic                              mem_wr_o,
  output logic [$clog2(NUM_BANKS*DEPTH)-1:0] mem_wr_addr_o,
  output logic [WORD_W-1:0]                 mem_wr_word_o,
  output logic [WORD_W-1:0]                 pop_word_o,
  output logic                              pop_valid_o,
  output logic                              fill_full_o,
  output logic                              drain_empty_o,
  output logic                              push_err_o,
  output logic                              pop_err_o
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PAW = $clog2(NUM_BANKS * DEPTH);

  logic fill_sel;  // which of the two banks the producer writes

  logic [BANKS_PER_PAIR-1:0] b_push, b_pop, b_clr, b_full, b_empty, b_pok, b_rok;
  logic [PW-1:0]             b_wp [BANKS_PER_PAIR];
  logic [PW-1:0]             b_rp [BANKS_PER_PAIR];

  for (genvar k = 0; k < BANKS_PER_PAIR; k++) begin : g_bank
    assign b_push[k] = push_i  && (fill_sel == k[0]);
    assign b_pop[k]  = pop_i   && (fill_sel != k[0]);
    // the drain bank is handed back to the producer empty
    assign b_clr[k]  = frame_i && (fill_sel != k[0]);
    ppaf_bank_ctrl #(.DEPTH(DEPTH)) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .push_i   (b_push[k]),
      .pop_i    (b_pop[k]),
      .clear_i  (b_clr[k]),
      .wptr_o   (b_wp[k]),
      .rptr_o   (b_rp[k]),
      .full_o   (b_full[k]),
      .empty_o  (b_empty[k]),
      .push_ok_o(b_pok[k]),
      .pop_ok_o (b_rok[k])
    );
  end

  logic wr_ok, rd_ok;
  assign wr_ok         = |b_pok;
  assign rd_ok         = |b_rok;
  assign fill_full_o   = b_full[fill_sel];
  assign drain_empty_o = b_empty[!fill_sel];

  assign mem_wr_o      = wr_ok;
  assign mem_wr_addr_o = PAW'(bank_base(PAIR_IDX, fill_sel, DEPTH)) + PAW'(b_wp[fill_sel]);
  assign mem_wr_word_o = push_word_i;
  assign mem_rd_o      = rd_ok;
  assign mem_rd_addr_o = PAW'(bank_base(PAIR_IDX, !fill_sel, DEPTH)) + PAW'(b_rp[!fill_sel]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fill_sel    <= 1'b0;
      pop_word_o  <= '0;
      pop_valid_o <= 1'b0;
      push_err_o  <= 1'b0;
      pop_err_o   <= 1'b0;
    end else begin
      if (frame_i) fill_sel <= !fill_sel;
      pop_valid_o <= rd_ok;
      push_err_o  <= push_i && fill_full_o;
      pop_err_o   <= pop_i && drain_empty_o;
      if (rd_ok) pop_word_o <= hold_word_i;
    end
  end
endmodule

// File: rtl/ppaf_slot_mem.sv
module ppaf_slot_mem
  import ppaf_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int DEPTH  = 256
) (
  input  logic                                          clk_mem_i,
  input  logic                                          rst_i,
  input  logic [NUM_PAIRS-1:0]                          rd_i,
  input  logic [NUM_PAIRS-1:0][$clog2(NUM_BANKS*DEPTH)-1:0] rd_addr_i,
  input  logic [NUM_PAIRS-1:0]                          wr_i,
  input  logic [NUM_PAIRS-1:0][$clog2(NUM_BANKS*DEPTH)-1:0] wr_addr_i,
  input  logic [NUM_PAIRS-1:0][WORD_W-1:0]              wr_word_i,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0]              hold_o
);
  localparam int WORDS = NUM_BANKS * DEPTH;
  localparam int PAW   = $clog2(WORDS);

  logic [SLOT_W-1:0] slot;
  logic              m_we;
  logic [PAW-1:0]    m_addr;
  logic [WORD_W-1:0] m_wdata, m_rdata;
  logic [WORD_W-1:0] ram [WORDS];

  // slot counter: 0 on the first memory edge after a FIFO edge
  always_ff @(posedge clk_mem_i) begin
    if (rst_i) slot <= '0;
    else       slot <= slot + 1'b1;
  end

  // slots 0..NUM_PAIRS-1 read, the remaining slots write
  always_comb begin
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (slot == SLOT_W'(p)) m_addr = rd_addr_i[p];
      if (slot == SLOT_W'(NUM_PAIRS + p)) begin
        m_we    = wr_i[p];
        m_addr  = wr_addr_i[p];
        m_wdata = wr_word_i[p];
      end
    end
  end

  always_ff @(posedge clk_mem_i) begin
    if (m_we) ram[m_addr] <= m_wdata;
    m_rdata <= ram[m_addr];
  end

  // capture a read one memory edge after its slot, well before the FIFO edge
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_hold
    always_ff @(posedge clk_mem_i) begin
      if (rst_i)                                   hold_o[p] <= '0;
      else if (rd_i[p] && slot == SLOT_W'(p + 1))  hold_o[p] <= m_rdata;
    end
  end
endmodule

// File: rtl/ppaf_top.sv
module ppaf_top
  import ppaf_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int DEPTH  = 256
) (
  input  logic                              clk_i,
  input  logic                              clk_mem_i,
  input  logic                              rst_i,
  input  logic [NUM_PAIRS-1:0]              push_i,
  input  logic [NUM_PAIRS-1:0][WORD_W-1:0]  push_word_i,
  input  logic [NUM_PAIRS-1:0]              pop_i,
  input  logic [NUM_PAIRS-1:0]              frame_i,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0]  pop_word_o,
  output logic [NUM_PAIRS-1:0]              pop_valid_o,
  output logic [NUM_PAIRS-1:0]              fill_full_o,
  output logic [NUM_PAIRS-1:0]              drain_empty_o,
  output logic [NUM_PAIRS-1:0]              push_err_o,
  output logic [NUM_PAIRS-1:0]              pop_err_o
);
  localparam int PAW = $clog2(NUM_BANKS * DEPTH);

  logic [NUM_PAIRS-1:0]              rd_req, wr_req;
  logic [NUM_PAIRS-1:0][PAW-1:0]     rd_addr, wr_addr;
  logic [NUM_PAIRS-1:0][WORD_W-1:0]  wr_word, hold;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    ppaf_pair_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PAIR_IDX(p)) u_pair (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .push_i       (push_i[p]),
      .push_word_i  (push_word_i[p]),
      .pop_i        (pop_i[p]),
      .frame_i      (frame_i[p]),
      .hold_word_i  (hold[p]),
      .mem_rd_o     (rd_req[p]),
      .mem_rd_addr_o(rd_addr[p]),
      .mem_wr_o     (wr_req[p]),
      .mem_wr_addr_o(wr_addr[p]),
      .mem_wr_word_o(wr_word[p]),
      .pop_word_o   (pop_word_o[p]),
      .pop_valid_o  (pop_valid_o[p]),
      .fill_full_o  (fill_full_o[p]),
      .drain_empty_o(drain_empty_o[p]),
      .push_err_o   (push_err_o[p]),
      .pop_err_o    (pop_err_o[p])
    );
  end

  ppaf_slot_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_mem_i(clk_mem_i),
    .rst_i    (rst_i),
    .rd_i     (rd_req),
    .rd_addr_i(rd_addr),
    .wr_i     (wr_req),
    .wr_addr_i(wr_addr),
    .wr_word_i(wr_word),
    .hold_o   (hold)
  );
endmodule

// File: rtl/ppaf_chk.sv
module ppaf_chk #(
  parameter int NP = 2,
  parameter int W  = 20
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic [NP-1:0]        push_i,
  input logic [NP-1:0]        pop_i,
  input logic [NP-1:0]        frame_i,
  input logic [NP-1:0][W-1:0] pop_word_o,
  input logic [NP-1:0]        pop_valid_o,
  input logic [NP-1:0]        fill_full_o,
  input logic [NP-1:0]        drain_empty_o,
  input logic [NP-1:0]        push_err_o,
  input logic [NP-1:0]        pop_err_o
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R6
    full_push_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (push_i[p] && fill_full_o[p]) |=> push_err_o[p]);
    // R6
    no_false_push_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(push_i[p] && fill_full_o[p]) |=> !push_err_o[p]);
    // R7
    empty_pop_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pop_i[p] && drain_empty_o[p]) |=> (pop_err_o[p] && !pop_valid_o[p]));
    // R5
    pop_return_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pop_i[p] && !drain_empty_o[p]) |=> (pop_valid_o[p] && !pop_err_o[p]));
    // R5
    word_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !pop_valid_o[p] |-> $stable(pop_word_o[p]));
    // R3
    drain_isolated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!frame_i[p] && drain_empty_o[p]) |=> drain_empty_o[p]);
    // R4
    swap_clears_fill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_i[p] |=> !fill_full_o[p]);
  end
endmodule

bind ppaf_top ppaf_chk #(.NP(ppaf_pkg::NUM_PAIRS), .W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .frame_i      (frame_i),
  .pop_word_o   (pop_word_o),
  .pop_valid_o  (pop_valid_o),
  .fill_full_o  (fill_full_o),
  .drain_empty_o(drain_empty_o),
  .push_err_o   (push_err_o),
  .pop_err_o    (pop_err_o)
);

// File: tb/sim_ppaf_top.sv
`timescale 1ns/100ps
module sim_ppaf_top;
  localparam int W = 20;
  localparam int D = 16;
  typedef logic [W-1:0] w_t;

  logic clk_s = 1'b0, clk_f = 1'b0, rst = 1'b1;
  logic [1:0]        push_i = '0, pop_i = '0, frame_i = '0;
  logic [1:0][W-1:0] push_word_i = '0;
  logic [1:0][W-1:0] pop_word_o;
  logic [1:0]        pop_valid_o, fill_full_o, drain_empty_o, push_err_o, pop_err_o;

  ppaf_top #(.WORD_W(W), .DEPTH(D)) u0 (
    .clk_i(clk_s), .clk_mem_i(clk_f), .rst_i(rst),
    .push_i(push_i), .push_word_i(push_word_i), .pop_i(pop_i), .frame_i(frame_i),
    .pop_word_o(pop_word_o), .pop_valid_o(pop_valid_o), .fill_full_o(fill_full_o),
    .drain_empty_o(drain_empty_o), .push_err_o(push_err_o), .pop_err_o(pop_err_o)
  );

  // 50 MHz FIFO clock, memory clock 4x, rising edges aligned
  initial begin
    int k;
    k = 0;
    forever begin
      clk_f = 1'b1;
      if (k % 4 == 0) clk_s = 1'b1;
      if (k % 4 == 2) clk_s = 1'b0;
      #2.5 clk_f = 1'b0;
      #2.5 k++;
    end
  end

  int vecs = 0, miss = 0, cyc = 0;
  w_t fillq [2][$];
  w_t drainq[2][$];
  w_t expq  [2][$];
  w_t last  [2];
  w_t seq   [2];
  logic [1:0] exp_perr, exp_oerr;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  always @(posedge clk_s) cyc++;

  // monitor: compares popped words against the scoreboard
  initial begin
    last[0] = '0; last[1] = '0;
    forever begin
      @(posedge clk_s); #1;
      if (!rst) begin
        for (int p = 0; p < 2; p++) begin
          if (pop_valid_o[p]) begin
            if (expq[p].size() == 0) chk(0, "R5 unexpected pop_valid", 32'(pop_word_o[p]), 0);
            else begin
              w_t e;
              e = expq[p].pop_front();
              chk(pop_word_o[p] == e, "R2/R5 popped word order", 32'(pop_word_o[p]), 32'(e));
            end
            last[p] = pop_word_o[p];
          end else begin
            chk(pop_word_o[p] == last[p], "R7 pop_word kept when no valid", 32'(pop_word_o[p]), 32'(last[p]));
          end
        end
      end
    end
  end

  // driver: one FIFO cycle, inputs driven 2 ns after the edge
  task automatic step(input logic [1:0] pu, input logic [1:0] po, input logic [1:0] sw);
    for (int p = 0; p < 2; p++) begin
      bit full, empty;
      seq[p]++;
      push_i[p]      = pu[p];
      pop_i[p]       = po[p];
      frame_i[p]     = sw[p];
      push_word_i[p] = {p[0], seq[p][W-2:0]};
      full  = (fillq[p].size() == D);
      empty = (drainq[p].size() == 0);
      chk(fill_full_o[p] == full, "R6 fill_full_o", 32'(fill_full_o[p]), 32'(full));
      chk(drain_empty_o[p] == empty, "R3 drain_empty_o", 32'(drain_empty_o[p]), 32'(empty));
      exp_perr[p] = pu[p] && full;
      exp_oerr[p] = po[p] && empty;
      if (po[p] && !empty) expq[p].push_back(drainq[p].pop_front());
      if (pu[p] && !full)  fillq[p].push_back(push_word_i[p]);
      if (sw[p]) begin  // R4 / R9: fill becomes drain, old drain discarded
        drainq[p] = fillq[p];
        fillq[p].delete();
      end
    end
    @(posedge clk_s); #2;
    for (int p = 0; p < 2; p++) begin
      chk(push_err_o[p] == exp_perr[p], "R6 push_err_o", 32'(push_err_o[p]), 32'(exp_perr[p]));
      chk(pop_err_o[p] == exp_oerr[p], "R7 pop_err_o", 32'(pop_err_o[p]), 32'(exp_oerr[p]));
    end
  endtask

  initial begin
    seq[0] = '0; seq[1] = '0;
    repeat (3) @(posedge clk_s);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    chk(drain_empty_o == 2'b11, "R1 drain_empty_o", 32'(drain_empty_o), 3);
    chk(fill_full_o == 2'b00, "R1 fill_full_o", 32'(fill_full_o), 0);
    chk(pop_valid_o == 2'b00, "R1 pop_valid_o", 32'(pop_valid_o), 0);
    chk({push_err_o, pop_err_o} == 4'b0, "R1 error flags", 32'({push_err_o, pop_err_o}), 0);
    chk(pop_word_o == '0, "R1 pop_word_o", 32'(pop_word_o[0]), 0);

    step(2'b00, 2'b11, 2'b00);                        // R7 pop both empty
    for (int i = 0; i < 5; i++) step(2'b01, 2'b00, 2'b00);  // R3 stays empty
    step(2'b00, 2'b00, 2'b01);                        // R4 swap pair 0
    for (int i = 0; i < 3; i++) step(2'b00, 2'b01, 2'b00);  // R2 R5
    step(2'b00, 2'b00, 2'b00);
    for (int i = 0; i < 3; i++) step(2'b00, 2'b01, 2'b00);  // last one R7
    // R8 both pairs concurrently
    for (int i = 0; i < 6; i++) step(2'b11, 2'b00, 2'b00);
    step(2'b00, 2'b00, 2'b11);
    for (int i = 0; i < 6; i++) step(2'b11, 2'b11, 2'b00);
    step(2'b00, 2'b00, 2'b11);
    for (int i = 0; i < 3; i++) step(2'b11, 2'b11, 2'b00);
    // R9 push on swap, R4 leftovers discarded
    step(2'b11, 2'b00, 2'b11);
    for (int i = 0; i < 5; i++) step(2'b00, 2'b11, 2'b00);
    step(2'b00, 2'b00, 2'b11);
    for (int i = 0; i < 5; i++) step(2'b00, 2'b11, 2'b00);
    // R6 fill pair 1 to DEPTH and beyond
    for (int i = 0; i < D + 2; i++) step(2'b10, 2'b01, 2'b00);
    step(2'b00, 2'b00, 2'b10);
    for (int i = 0; i < D + 1; i++) step(2'b01, 2'b10, 2'b00);
    step(2'b00, 2'b00, 2'b11);
    for (int i = 0; i < D + 2; i++) step(2'b00, 2'b11, 2'b00);
    repeat (2) step(2'b00, 2'b00, 2'b00);
    for (int p = 0; p < 2; p++)
      chk(expq[p].size() == 0, "R2 all expected words returned", 32'(expq[p].size()), 0);
    done = 1;
    summary();
    $finish;
  end

  // watchdog
  initial begin
    wait (cyc > 20000);
    if (!done) begin
      chk(0, "watchdog expired", 32'(cyc), 20000);
      summary();
      $finish;
    end
  end
endmodule